// File: doc/BRIEF.md
# Split-Word Interrupt Register Bank

This block is the software-visible register bank of a 51-source interrupt controller. Software reaches it through 32-bit accesses. Each 51-bit control or status vector occupies two word addresses: one word holds source bits 31:0 and the other holds source bits 50:32. The bank stores the routing (select), enable and event-polarity vectors. It exposes the sense and both-edge configuration as read-only constants. It also gives read-only views of the raw, routed and edge-pending status.

The raw pending vector comes from a separate trigger detector. The bank drives two request lines, a normal request and a fast request. Each line is the OR of the enabled pending sources that the select vector routes to it. Enable bits are changed through a set address and a clear address, so software never needs a read-modify-write. A write to the edge-clear address sends a one-cycle clear pulse back to the detector. The pulse covers only the edge-type sources. Addresses below the register window belong to an older register layout. This bank ignores them.

Top module: `intc_regbank`

## Requirements
- R1: Any access with a byte address below 0x80 has no effect: reads return 0 and writes leave all stored vectors unchanged.
- R2: Within the window, address bit 2 selects the word. Bit 2 = 0 maps source bits 31:0 to data bits 31:0. Bit 2 = 1 maps source bits 50:32 to data bits 18:0, reads 0 in data bits 31:19, and ignores written data bits 31:19.
- R3: After reset, sense = 0x1F07FFF8FFFF, both-edge = 0xF800070000, event = 0x5F07FFF8FFFF, select = 0, enable = 0, read data = 0, clear pulse = 0, and both request lines are low.
- R4: A write to select (0x98 low, 0x9C high) replaces only the addressed word and leaves the other word unchanged.
- R5: A write to the enable-set address (0xA0/0xA4) ORs the written bits into enable.
- R6: A write to the enable-clear address (0xA8/0xAC) clears the written bits from enable.
- R7: Status reads return the following. Normal status (0x80/0x84) is raw AND enable AND NOT select. Fast status (0x88/0x8C) is raw AND enable AND select. Raw (0x90/0x94) is the raw input. Edge status (0xE0/0xE4) is raw AND NOT sense.
- R8: The event register reads at 0xD0/0xD4. A write to its high word 0xD4 replaces only event bits 50:47. A write to its low word 0xD0 is ignored.
- R9: A write to 0xD8/0xDC drives the written bits, masked to sources whose sense bit is 0, on the clear-pulse output for exactly one cycle. The pulse appears in the cycle after the write.
- R10: Sense (0xC0/0xC4) and both-edge (0xC8/0xCC) ignore writes. The clear addresses, the software-trigger pair (0xB0–0xBC), misaligned addresses and unmapped offsets (0xE8 and up) read 0. Writes to these addresses change nothing.
- R11: The fast request is high when any bit of raw AND enable AND select is set. The normal request is high when any bit of raw AND enable AND NOT select is set.
- R12: Read data is registered: it updates in the cycle after a read request and holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| raw_i | input | 51 | Raw pending vector from the trigger detector |
| edge_clr_o | output | 51 | One-cycle clear pulse to the trigger detector |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach from the ports is a half-word update that must not disturb the other half. An example is a select write to one word while the other word holds a distinct value. Another is an event high-word write that may touch only bits 50:47 while the constant bit 46 survives. The stimulus first loads both select words with different patterns, then rewrites one word and reads both back. For the event register it writes all ones and then all zeros to the high word and compares the result against the reset pattern. The clear pulse is sampled in the first and second cycles after the write, so both its masking and its one-cycle width are observed.

// File: rtl/intc_regbank_pkg.sv
package intc_regbank_pkg;

  // slot index = (byte offset from window base) / 8
  typedef enum logic [3:0] {
    SLOT_IRQ_ST   = 4'd0,
    SLOT_FIQ_ST   = 4'd1,
    SLOT_RAW      = 4'd2,
    SLOT_SEL      = 4'd3,
    SLOT_EN_SET   = 4'd4,
    SLOT_EN_CLR   = 4'd5,
    SLOT_SW_SET   = 4'd6,
    SLOT_SW_CLR   = 4'd7,
    SLOT_SENSE    = 4'd8,
    SLOT_DUAL     = 4'd9,
    SLOT_EVENT    = 4'd10,
    SLOT_EDGE_CLR = 4'd11,
    SLOT_EDGE_ST  = 4'd12,
    SLOT_NONE     = 4'd15
  } slot_e;

  localparam int unsigned LAST_SLOT = 12;

  typedef struct packed {
    logic  hi;
    slot_e slot;
  } acc_t;

endpackage

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
  import intc_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 'h80
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o
);
  localparam int unsigned         IDX_W  = ADDR_W - 3;
  localparam logic [ADDR_W-1:0]   BASE_A = ADDR_W'(BASE);

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic              hit;

  always_comb begin
    rel = addr_i - BASE_A;
    idx = rel[ADDR_W-1:3];
    hit = (addr_i >= BASE_A) && (rel[1:0] == 2'b00) && (int'(idx) <= LAST_SLOT);
    acc_o.hi   = rel[2];
    acc_o.slot = hit ? slot_e'(idx[3:0]) : SLOT_NONE;
  end

endmodule

// File: rtl/intc_vec_store.sv
module intc_vec_store
  import intc_regbank_pkg::*;
#(
  parameter int unsigned          N_SRC    = 51,
  parameter int unsigned          DATA_W   = 32,
  parameter logic [N_SRC-1:0]     SENSE    = 51'h1F07FFF8FFFF,
  parameter logic [N_SRC-1:0]     EVT_RST  = 51'h5F07FFF8FFFF,
  parameter logic [N_SRC-1:0]     EVT_WR   = 51'h7800000000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  acc_t              acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_SRC-1:0]  sel_o,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  evt_o,
  output logic [N_SRC-1:0]  edge_clr_o
);
  localparam int unsigned HI_W = N_SRC - DATA_W;

  logic [N_SRC-1:0] wvec, half;

  // place write data into the addressed half, high half masked to HI_W bits
  always_comb begin
    if (acc_i.hi) begin
      wvec = {wdata_i[HI_W-1:0], {DATA_W{1'b0}}};
      half = {{HI_W{1'b1}}, {DATA_W{1'b0}}};
    end else begin
      wvec = {{HI_W{1'b0}}, wdata_i};
      half = {{HI_W{1'b0}}, {DATA_W{1'b1}}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o      <= '0;
      en_o       <= '0;
      evt_o      <= EVT_RST;
      edge_clr_o <= '0;
    end else begin
      edge_clr_o <= '0;
      if (wr_i) begin
        unique case (acc_i.slot)
          SLOT_SEL:      sel_o <= (sel_o & ~half) | wvec;
          SLOT_EN_SET:   en_o  <= en_o | wvec;
          SLOT_EN_CLR:   en_o  <= en_o & ~wvec;
          SLOT_EVENT:    if (acc_i.hi) evt_o <= (evt_o & ~EVT_WR) | (wvec & EVT_WR);
          SLOT_EDGE_CLR: edge_clr_o <= wvec & ~SENSE;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/intc_rd_out.sv
module intc_rd_out
  import intc_regbank_pkg::*;
#(
  parameter int unsigned      N_SRC  = 51,
  parameter int unsigned      DATA_W = 32,
  parameter logic [N_SRC-1:0] SENSE  = 51'h1F07FFF8FFFF,
  parameter logic [N_SRC-1:0] DUAL   = 51'h00F800070000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  acc_t              acc_i,
  input  logic [N_SRC-1:0]  raw_i,
  input  logic [N_SRC-1:0]  sel_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic [N_SRC-1:0]  evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [N_SRC-1:0]  pend, view;
  logic [DATA_W-1:0] word;

  assign pend  = raw_i & en_i;
  assign irq_o = |(pend & ~sel_i);
  assign fiq_o = |(pend & sel_i);

  always_comb begin
    unique case (acc_i.slot)
      SLOT_IRQ_ST:  view = pend & ~sel_i;
      SLOT_FIQ_ST:  view = pend & sel_i;
      SLOT_RAW:     view = raw_i;
      SLOT_SEL:     view = sel_i;
      SLOT_EN_SET:  view = en_i;
      SLOT_SENSE:   view = SENSE;
      SLOT_DUAL:    view = DUAL;
      SLOT_EVENT:   view = evt_i;
      SLOT_EDGE_ST: view = raw_i & ~SENSE;
      default:      view = '0;  // clear strobes, software trigger, unmapped
    endcase
    word = acc_i.hi ? DATA_W'(view[N_SRC-1:DATA_W]) : view[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= word;
  end

endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
  import intc_regbank_pkg::*;
#(
  parameter int unsigned      N_SRC     = 51,
  parameter int unsigned      DATA_W    = 32,
  parameter int unsigned      ADDR_W    = 8,
  parameter int unsigned      BASE      = 'h80,
  parameter logic [N_SRC-1:0] SENSE_RST = 51'h1F07FFF8FFFF,
  parameter logic [N_SRC-1:0] DUAL_RST  = 51'h00F800070000,
  parameter logic [N_SRC-1:0] EVT_RST   = 51'h5F07FFF8FFFF,
  parameter logic [N_SRC-1:0] EVT_WR    = 51'h7800000000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  raw_i,
  output logic [N_SRC-1:0]  edge_clr_o,
  output logic              irq_o,
  output logic              fiq_o
);
  acc_t             acc;
  logic [N_SRC-1:0] sel_q, en_q, evt_q;

  intc_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) i_dec (
    .addr_i (addr_i),
    .acc_o  (acc)
  );

  intc_vec_store #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .SENSE(SENSE_RST),
    .EVT_RST(EVT_RST), .EVT_WR(EVT_WR)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (req_i & we_i),
    .acc_i      (acc),
    .wdata_i    (wdata_i),
    .sel_o      (sel_q),
    .en_o       (en_q),
    .evt_o      (evt_q),
    .edge_clr_o (edge_clr_o)
  );

  intc_rd_out #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .SENSE(SENSE_RST), .DUAL(DUAL_RST)
  ) i_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (req_i & ~we_i),
    .acc_i   (acc),
    .raw_i   (raw_i),
    .sel_i   (sel_q),
    .en_i    (en_q),
    .evt_i   (evt_q),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o)
  );

endmodule

// File: rtl/intc_regbank_chk.sv
module intc_regbank_chk #(
  parameter int unsigned      N_SRC     = 51,
  parameter int unsigned      DATA_W    = 32,
  parameter int unsigned      ADDR_W    = 8,
  parameter int unsigned      BASE      = 'h80,
  parameter logic [N_SRC-1:0] SENSE_RST = 51'h1F07FFF8FFFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_SRC-1:0]  raw_i,
  input logic [N_SRC-1:0]  edge_clr_o,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [N_SRC-1:0]  sel_q,
  input logic [N_SRC-1:0]  en_q,
  input logic [N_SRC-1:0]  evt_q
);
  localparam int unsigned       HI_W   = N_SRC - DATA_W;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(BASE + 'h18);
  localparam logic [ADDR_W-1:0] A_ENS  = ADDR_W'(BASE + 'h20);
  localparam logic [ADDR_W-1:0] A_ENC  = ADDR_W'(BASE + 'h28);
  localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(BASE + 'h50);

  logic rd, wr;
  assign rd = req_i && !we_i;
  assign wr = req_i && we_i;

  a_r1_legacy_rd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && (addr_i < BASE_A) |=> rdata_o == '0);

  a_r1_legacy_wr_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && (addr_i < BASE_A) |=> $stable(sel_q) && $stable(en_q) && $stable(evt_q));

  a_r2_hi_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && (addr_i >= BASE_A) && addr_i[2] |=> rdata_o[DATA_W-1:HI_W] == '0);

  a_r4_sel_lo_keeps_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && (addr_i == A_SEL) |=> sel_q[N_SRC-1:DATA_W] == $past(sel_q[N_SRC-1:DATA_W]));

  a_r5_en_set_no_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && (addr_i[ADDR_W-1:3] == A_ENS[ADDR_W-1:3]) |=> (en_q & $past(en_q)) == $past(en_q));

  a_r6_en_clr_no_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && (addr_i[ADDR_W-1:3] == A_ENC[ADDR_W-1:3]) |=> (en_q | $past(en_q)) == $past(en_q));

  a_r8_evt_lo_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && (addr_i == A_EVT) |=> $stable(evt_q));

  a_r9_clr_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_clr_o & SENSE_RST) == '0);

  a_r9_clr_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_clr_o != '0) |-> $past(wr));

  a_r11_req_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || fiq_o) |-> |(raw_i & en_q));

endmodule

bind intc_regbank intc_regbank_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE), .SENSE_RST(SENSE_RST)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .raw_i      (raw_i),
  .edge_clr_o (edge_clr_o),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .sel_q      (sel_q),
  .en_q       (en_q),
  .evt_q      (evt_q)
);

// File: tb/test_intc_regbank.sv
`timescale 1ns/1ps
module test_intc_regbank;
  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [50:0] raw = '0, edge_clr;
  logic        irq, fiq;
  logic        rd_fire = 1'b0;
  int          errs = 0, checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  intc_regbank i_intc_regbank (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .raw_i(raw), .edge_clr_o(edge_clr),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per completed read
  always @(posedge clk) rd_fire <= req && !we;
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) check("read without expectation", 64'(rdata), 64'hDEAD);
      else check(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    check("R3 irq", 64'(irq), 0); check("R3 fiq", 64'(fiq), 0);
    check("R3 rdata", 64'(rdata), 0); check("R3 edge_clr", 64'(edge_clr), 0);
    rd(8'hC0, 32'hFFF8FFFF, "R3 sense lo"); rd(8'hC4, 32'h1F07, "R3 sense hi");
    rd(8'hC8, 32'h00070000, "R3 dual lo");  rd(8'hCC, 32'hF8, "R3 dual hi");
    rd(8'hD0, 32'hFFF8FFFF, "R3 event lo"); rd(8'hD4, 32'h5F07, "R3 event hi");
    rd(8'h98, 0, "R3 select"); rd(8'hA0, 0, "R3 enable");
    // R1 legacy window
    wr(8'h20, 32'hFFFFFFFF); wr(8'h18, 32'hFFFFFFFF);
    rd(8'h20, 0, "R1 legacy read"); rd(8'hA0, 0, "R1 enable untouched");
    rd(8'h98, 0, "R1 select untouched");
    // R5 / R2 enable set and high-word masking
    wr(8'hA0, 32'hF0); wr(8'hA4, 32'hFFFFFFFF);
    rd(8'hA4, 32'h7FFFF, "R2 high word masked");
    wr(8'hA0, 32'h0F);
    rd(8'hA0, 32'hFF, "R5 enable OR");
    // R6 enable clear
    wr(8'hA8, 32'h0F); rd(8'hA0, 32'hF0, "R6 clear low");
    rd(8'hA8, 0, "R10 clear reads zero");
    wr(8'hAC, 32'h7FFF0); rd(8'hA4, 32'hF, "R6 clear high");
    // R4 select halves, R2 high data masking
    wr(8'h98, 32'hC0); wr(8'h9C, 32'hFFF80001); wr(8'h98, 32'h30);
    rd(8'h9C, 32'h1, "R4 high kept / R2 mask"); rd(8'h98, 32'h30, "R4 low replaced");
    // R7 status views, R11 outputs (en lo=F0 hi=F, sel lo=30 hi=1)
    @(negedge clk); raw = {19'h1, 32'h000700F0};
    rd(8'h80, 32'hC0, "R7 irq status lo"); rd(8'h84, 0, "R7 irq status hi");
    rd(8'h88, 32'h30, "R7 fiq status lo"); rd(8'h8C, 32'h1, "R7 fiq status hi");
    rd(8'h90, 32'h000700F0, "R7 raw lo"); rd(8'h94, 32'h1, "R7 raw hi");
    rd(8'hE0, 32'h00070000, "R7 edge status lo"); rd(8'hE4, 0, "R7 edge status hi");
    check("R11 irq both", 64'(irq), 1); check("R11 fiq both", 64'(fiq), 1);
    raw = 51'hC0; #1;
    check("R11 irq only", 64'(irq), 1); check("R11 fiq off", 64'(fiq), 0);
    raw = {19'h1, 32'h0}; #1;
    check("R11 irq off", 64'(irq), 0); check("R11 fiq only", 64'(fiq), 1);
    raw = 51'hF00; #1;
    check("R11 disabled irq", 64'(irq), 0); check("R11 disabled fiq", 64'(fiq), 0);
    // R8 event
    wr(8'hD0, 32'h0); rd(8'hD0, 32'hFFF8FFFF, "R8 low ignored");
    wr(8'hD4, 32'hFFFFFFFF); rd(8'hD4, 32'h7DF07, "R8 top four set");
    wr(8'hD4, 32'h0); rd(8'hD4, 32'h5F07, "R8 top four cleared");
    // R9 edge clear pulse
    wr(8'hD8, 32'hFFFFFFFF);
    check("R9 pulse lo", 64'(edge_clr), 64'h70000);
    @(negedge clk); check("R9 pulse ends", 64'(edge_clr), 0);
    wr(8'hDC, 32'hFFFFFFFF);
    check("R9 pulse hi", 64'(edge_clr), {13'h0, 19'h7E0F8, 32'h0});
    @(negedge clk); check("R9 pulse ends hi", 64'(edge_clr), 0);
    rd(8'hD8, 0, "R10 edge clear reads zero");
    // R10 read-only, software trigger, unmapped, misaligned
    wr(8'hC0, 32'h0); wr(8'hCC, 32'h0);
    rd(8'hC0, 32'hFFF8FFFF, "R10 sense read-only"); rd(8'hCC, 32'hF8, "R10 dual read-only");
    wr(8'hB0, 32'hFFFFFFFF); rd(8'hB0, 0, "R10 sw trigger"); rd(8'hB8, 0, "R10 sw clear");
    wr(8'hE8, 32'hFFFFFFFF); rd(8'hE8, 0, "R10 unmapped");
    wr(8'hA1, 32'hFFFFFFFF); rd(8'hA0, 32'hF0, "R10 misaligned write ignored");
    rd(8'hA1, 0, "R10 misaligned read");
    // R12 read data holds
    rd(8'hCC, 32'hF8, "R12 read");
    wr(8'h98, 32'h30);
    repeat (2) @(negedge clk);
    check("R12 rdata held", 64'(rdata), 32'hF8);
    repeat (2) @(negedge clk);
    check("scoreboard drained", 64'(exp_q.size()), 0);
    summary();
  end
endmodule